// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block sits behind a test access port and gives a debugger read and write access to a bank of addressed 32-bit debug registers: breakpoint value and control registers, watchpoint value and control registers, and one vector catch register. Each register is reached through a single 40-bit chain. The debugger shifts in an access word, and the Update-DR strobe launches the access into the register bank through an internal request and acknowledge handshake.

Accesses are pipelined. The Capture-DR of each scan loads the outcome of the request from the scan before it: a Ready flag, the read data or the echoed write data, and the address of that earlier request. The debugger therefore runs one extra scan after the last request to collect its result.

If the bank is still busy at capture, Ready comes back 0. The update of that same scan is then dropped, and the debugger repeats the scan. The bit 0 of each breakpoint and watchpoint control register, and any non-zero value in the vector catch register, drive enable outputs toward the core's debug logic.

Top module: `dbgreg_chain_top`

## Requirements
- R1: The chain is 40 bits and shifts from `tdi` toward `tdo`. Bits 6:0 (address) leave first, then bits 38:7 (data), then bit 39, which is the flag bit. The debugger shifts its word in the same order, least significant bit first.
- R2: In a shifted-in word, bit 39 set to 1 requests a write of bits 38:7 to address bits 6:0. Bit 39 set to 0 requests a read.
- R3: Capture-DR loads the result of the most recently launched request, together with that request's address.
- R4: For a read, the captured data is the register contents. For a write, the captured data echoes the value that was written, and the register holds that value afterwards.
- R5: The captured flag bit is Ready: it is 1 when the bank is idle and 0 while an access is still running. An update that follows a capture with Ready 0 launches nothing, and the debugger repeats the scan.
- R6: The mapped addresses are as follows. Breakpoint value n is at 0x40+n and breakpoint control n is at 0x50+n, for n < NUM_BKPT. Watchpoint value n is at 0x60+n and watchpoint control n is at 0x70+n, for n < NUM_WPT. Vector catch is at 0x07. Any other address reads as 0 and discards writes.
- R7: After reset, Ready is 1, the captured address and data are 0, and all enable outputs are 0.
- R8: `bkpt_en[n]` and `wpt_en[n]` follow bit 0 of the matching control register. `vcatch_en` is 1 while the vector catch register is non-zero. Writing 0 disables each of them.
- R9: While `chain_sel` is low, the capture, shift and update strobes have no effect.
- R10: An access takes ACC_LAT+1 cycles. A capture at least ACC_LAT+1 idle cycles after the update sees Ready 1. A capture ACC_LAT idle cycles after the update sees Ready 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP clock |
| rst_n | input | 1 | synchronous active-low reset |
| chain_sel | input | 1 | this chain is the selected data register |
| capture_dr | input | 1 | Capture-DR strobe, one cycle |
| shift_dr | input | 1 | Shift-DR enable, one bit per cycle |
| update_dr | input | 1 | Update-DR strobe, one cycle |
| tdi | input | 1 | serial data in |
| tdo | output | 1 | serial data out (chain bit 0) |
| bkpt_en | output | NUM_BKPT | breakpoint enables |
| wpt_en | output | NUM_WPT | watchpoint enables |
| vcatch_en | output | 1 | vector catch active |

## Verification
The result of a request is due at the capture of the next scan, one full scan later. The Ready bit is due exactly ACC_LAT+1 cycles after the update cycle. The bench therefore compares every scan's output with the request issued one scan earlier, using a model it keeps itself. It places captures at controlled gaps of 0, ACC_LAT and ACC_LAT+1 idle cycles after an update to pin the Ready boundary. Enable outputs are sampled after the result scan that follows the write, when the write has certainly landed. All 128 addresses are swept, first with writes and then with reads.

// File: rtl/dbgreg_pkg.sv
// Package: shared chain word layout, register regions and the address decoder.
// Assumes the 40-bit layout {flag, data[31:0], addr[6:0]} with addr nearest tdo.
package dbgreg_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int CHAIN_W = 1 + DATA_W + ADDR_W;

    localparam logic [2:0] PG_BVAL  = 3'd4;
    localparam logic [2:0] PG_BCTL  = 3'd5;
    localparam logic [2:0] PG_WVAL  = 3'd6;
    localparam logic [2:0] PG_WCTL  = 3'd7;
    localparam logic [2:0] PG_MISC  = 3'd0;
    localparam logic [3:0] VEC_SLOT = 4'd7;

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } chain_word_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_BVAL, RG_BCTL, RG_WVAL, RG_WCTL, RG_VEC
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [3:0] idx;
    } decode_t;

    // Map an address to a region and slot; slots beyond the configured counts are unmapped.
    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a,
                                            input int nbk, input int nwp);
        decode_t d;
        d.idx = a[3:0];
        d.rg  = RG_NONE;
        case (a[6:4])
            PG_BVAL: if (int'(a[3:0]) < nbk) d.rg = RG_BVAL;
            PG_BCTL: if (int'(a[3:0]) < nbk) d.rg = RG_BCTL;
            PG_WVAL: if (int'(a[3:0]) < nwp) d.rg = RG_WVAL;
            PG_WCTL: if (int'(a[3:0]) < nwp) d.rg = RG_WCTL;
            PG_MISC: if (a[3:0] == VEC_SLOT) d.rg = RG_VEC;
            default: d.rg = RG_NONE;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/dbgreg_shift.sv
// Module: 40-bit capture/shift register of the chain.
// Loads the result word on Capture-DR and shifts tdi in at the top, tdo out at bit 0.
// Assumes capture and shift strobes are never high in the same cycle.
module dbgreg_shift
    import dbgreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        capture,
    input  logic        shift,
    input  logic        tdi,
    input  chain_word_t cap_word,
    output logic        tdo,
    output chain_word_t shadow
);
    logic [CHAIN_W-1:0] sr_q;

    // Capture the pending result or move the chain one bit toward tdo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sel && capture) begin
            sr_q <= cap_word;
        end else if (sel && shift) begin
            sr_q <= {tdi, sr_q[CHAIN_W-1:1]};
        end
    end

    assign tdo    = sr_q[0];
    assign shadow = chain_word_t'(sr_q);

    p_capture_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture) |=> (sr_q == $past(cap_word)));

    p_shift_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture) |=>
            (sr_q[CHAIN_W-2:0] == $past(sr_q[CHAIN_W-1:1])) && (sr_q[CHAIN_W-1] == $past(tdi)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> $stable(sr_q));
endmodule

// File: rtl/dbgreg_seq.sv
// Module: access sequencer. Accepts an update only if the same scan's capture saw the
// bank idle, holds the request to the bank until acknowledged, then keeps the
// result (data and address) for the next capture.
// Assumes the bank acknowledges with a one-cycle pulse while the request is held.
module dbgreg_seq
    import dbgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              capture,
    input  logic              update,
    input  chain_word_t       shadow,
    output chain_word_t       cap_word,
    output logic              rf_req,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic              rf_ack,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic              busy_q;
    logic              cap_ok_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] res_addr_q;
    logic [DATA_W-1:0] res_data_q;
    logic              launch;

    assign launch = sel && update && cap_ok_q && !busy_q;

    // Track whether this scan's capture saw an idle bank; an update always consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ok_q <= 1'b0;
        end else if (sel && capture) begin
            cap_ok_q <= !busy_q;
        end else if (sel && update) begin
            cap_ok_q <= 1'b0;
        end
    end

    // Launch a request on an accepted update and retire it on the bank acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            we_q       <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            res_addr_q <= '0;
            res_data_q <= '0;
        end else if (launch) begin
            busy_q  <= 1'b1;
            we_q    <= shadow.flag;
            addr_q  <= shadow.addr;
            wdata_q <= shadow.data;
        end else if (busy_q && rf_ack) begin
            busy_q     <= 1'b0;
            res_addr_q <= addr_q;
            res_data_q <= we_q ? wdata_q : rf_rdata;
        end
    end

    assign rf_req   = busy_q;
    assign rf_we    = we_q;
    assign rf_addr  = addr_q;
    assign rf_wdata = wdata_q;

    assign cap_word.flag = !busy_q;
    assign cap_word.data = res_data_q;
    assign cap_word.addr = res_addr_q;

    p_launch_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && update && busy_q) |=> (busy_q && $stable(addr_q) && $stable(wdata_q)));

    p_busy_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !rf_ack) |=> busy_q);

    p_result_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rf_ack) |=> (res_addr_q == $past(addr_q)) && !busy_q);
endmodule

// File: rtl/dbgreg_bank.sv
// Module: debug register storage with a fixed access latency.
// A held request is acknowledged ACC_LAT cycles after it appears; a write lands and the
// read value is registered in the acknowledge cycle. Unmapped slots read 0.
// Assumes the request and its fields stay stable until the acknowledge.
module dbgreg_bank
    import dbgreg_pkg::*;
#(
    parameter int NUM_BKPT = 6,
    parameter int NUM_WPT  = 2,
    parameter int ACC_LAT  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                ack,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_BKPT-1:0] bkpt_en,
    output logic [NUM_WPT-1:0]  wpt_en,
    output logic                vcatch_en
);
    localparam int CNT_W = $clog2(ACC_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_LAT - 1);

    logic [DATA_W-1:0] bval_q [NUM_BKPT];
    logic [DATA_W-1:0] bctl_q [NUM_BKPT];
    logic [DATA_W-1:0] wval_q [NUM_WPT];
    logic [DATA_W-1:0] wctl_q [NUM_WPT];
    logic [DATA_W-1:0] vec_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rd_now;
    logic              fire;
    logic              hit;
    decode_t           dec;

    assign dec  = decode_addr(addr, NUM_BKPT, NUM_WPT);
    assign hit  = (dec.rg != RG_NONE);
    assign fire = req && !ack && (cnt_q == CNT_LAST);

    // Select the addressed register for reading; unmapped slots give zero.
    always_comb begin
        rd_now = '0;
        for (int i = 0; i < NUM_BKPT; i++) begin
            if (dec.rg == RG_BVAL && dec.idx == 4'(i)) rd_now = bval_q[i];
            if (dec.rg == RG_BCTL && dec.idx == 4'(i)) rd_now = bctl_q[i];
        end
        for (int i = 0; i < NUM_WPT; i++) begin
            if (dec.rg == RG_WVAL && dec.idx == 4'(i)) rd_now = wval_q[i];
            if (dec.rg == RG_WCTL && dec.idx == 4'(i)) rd_now = wctl_q[i];
        end
        if (dec.rg == RG_VEC) rd_now = vec_q;
    end

    // Count the access latency and pulse the acknowledge with the read value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ack   <= 1'b0;
            rdata <= '0;
        end else if (ack) begin
            ack   <= 1'b0;
            cnt_q <= '0;
        end else if (fire) begin
            ack   <= 1'b1;
            cnt_q <= '0;
            rdata <= rd_now;
        end else if (req) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Store write data into the addressed register in the acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BKPT; i++) begin
                bval_q[i] <= '0;
                bctl_q[i] <= '0;
            end
            for (int i = 0; i < NUM_WPT; i++) begin
                wval_q[i] <= '0;
                wctl_q[i] <= '0;
            end
            vec_q <= '0;
        end else if (fire && we) begin
            for (int i = 0; i < NUM_BKPT; i++) begin
                if (dec.rg == RG_BVAL && dec.idx == 4'(i)) bval_q[i] <= wdata;
                if (dec.rg == RG_BCTL && dec.idx == 4'(i)) bctl_q[i] <= wdata;
            end
            for (int i = 0; i < NUM_WPT; i++) begin
                if (dec.rg == RG_WVAL && dec.idx == 4'(i)) wval_q[i] <= wdata;
                if (dec.rg == RG_WCTL && dec.idx == 4'(i)) wctl_q[i] <= wdata;
            end
            if (dec.rg == RG_VEC) vec_q <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < NUM_BKPT; g++) begin : g_bk_en
            assign bkpt_en[g] = bctl_q[g][0];
        end
        for (genvar g = 0; g < NUM_WPT; g++) begin : g_wp_en
            assign wpt_en[g] = wctl_q[g][0];
        end
    endgenerate
    assign vcatch_en = |vec_q;

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(!we && !hit)) |-> (rdata == '0));

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(fire && we && hit)) |-> (rd_now == $past(wdata)));
endmodule

// File: rtl/dbgreg_chain_top.sv
// Module: top of the debug register access chain. Joins the shift register,
// the access sequencer and the register bank.
// Assumes TAP strobes are one-cycle, mutually exclusive and synchronous to clk.
module dbgreg_chain_top
    import dbgreg_pkg::*;
#(
    parameter int NUM_BKPT = 6,
    parameter int NUM_WPT  = 2,
    parameter int ACC_LAT  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chain_sel,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    output logic                tdo,
    output logic [NUM_BKPT-1:0] bkpt_en,
    output logic [NUM_WPT-1:0]  wpt_en,
    output logic                vcatch_en
);
    chain_word_t       cap_word;
    chain_word_t       shadow;
    logic              rf_req;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_wdata;
    logic              rf_ack;
    logic [DATA_W-1:0] rf_rdata;

    dbgreg_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (chain_sel),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .tdi      (tdi),
        .cap_word (cap_word),
        .tdo      (tdo),
        .shadow   (shadow)
    );

    dbgreg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (chain_sel),
        .capture  (capture_dr),
        .update   (update_dr),
        .shadow   (shadow),
        .cap_word (cap_word),
        .rf_req   (rf_req),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata),
        .rf_ack   (rf_ack),
        .rf_rdata (rf_rdata)
    );

    dbgreg_bank #(
        .NUM_BKPT (NUM_BKPT),
        .NUM_WPT  (NUM_WPT),
        .ACC_LAT  (ACC_LAT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rf_req),
        .we        (rf_we),
        .addr      (rf_addr),
        .wdata     (rf_wdata),
        .ack       (rf_ack),
        .rdata     (rf_rdata),
        .bkpt_en   (bkpt_en),
        .wpt_en    (wpt_en),
        .vcatch_en (vcatch_en)
    );
endmodule

// File: tb/tb_dbgreg_chain_top.sv
module tb_dbgreg_chain_top;
    localparam int NB  = 6;
    localparam int NW  = 2;
    localparam int LAT = 3;
    localparam int GAP = LAT + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chain_sel = 1'b0;
    logic capture_dr = 1'b0;
    logic shift_dr = 1'b0;
    logic update_dr = 1'b0;
    logic tdi = 1'b0;
    logic tdo;
    logic [NB-1:0] bkpt_en;
    logic [NW-1:0] wpt_en;
    logic vcatch_en;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [128];
    bit          prev_we;
    logic [31:0] prev_d;
    logic [6:0]  prev_a;

    always #5 clk = ~clk;

    dbgreg_chain_top #(.NUM_BKPT(NB), .NUM_WPT(NW), .ACC_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .bkpt_en(bkpt_en), .wpt_en(wpt_en), .vcatch_en(vcatch_en)
    );

    function automatic bit mapped(input logic [6:0] a);
        case (a[6:4])
            3'd4, 3'd5: return int'(a[3:0]) < NB;
            3'd6, 3'd7: return int'(a[3:0]) < NW;
            3'd0:       return a[3:0] == 4'd7;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] pat(input int a);
        return 32'hC300_0000 ^ (32'(a) * 32'h0101_0101);
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One complete scan: capture, 40 shifts, update, then gap idle cycles.
    task automatic scan(input bit sel_i, input bit we, input logic [31:0] d,
                        input logic [6:0] a, input int gap, output logic [39:0] ob);
        logic [39:0] w;
        w = {we, d, a};
        chain_sel  = sel_i;
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        for (int i = 0; i < 40; i++) begin
            ob[i] = tdo;
            tdi   = w[i];
            @(negedge clk);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
        chain_sel = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    // Scan and compare with the request one scan earlier (R1, R2, R3, R4, R6, R5).
    task automatic step(input bit we, input logic [31:0] d, input logic [6:0] a,
                        input int gap, input bit exp_rdy);
        logic [39:0] ob;
        logic [31:0] ed;
        scan(1'b1, we, d, a, gap, ob);
        check("R5 ready", {39'd0, ob[39]}, {39'd0, exp_rdy});
        if (exp_rdy) begin
            ed = prev_we ? prev_d : (mapped(prev_a) ? mem[prev_a] : 32'd0);
            check("R3 echoed address", {33'd0, ob[6:0]}, {33'd0, prev_a});
            check(prev_we ? "R4 write echo" : (mapped(prev_a) ? "R4 read data" : "R6 unmapped read"),
                  {8'd0, ob[38:7]}, {8'd0, ed});
            if (we && mapped(a)) mem[a] = d;
            prev_we = we;
            prev_d  = d;
            prev_a  = a;
        end
    endtask

    initial begin
        logic [39:0] ob;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chain_sel = 1'b1;
        @(negedge clk);
        check("R7 enables after reset", {29'd0, bkpt_en, wpt_en, vcatch_en}, 40'd0);
        scan(1'b1, 1'b0, 32'd0, 7'd0, GAP, ob);
        check("R7 reset capture word", ob, {1'b1, 39'd0});
        prev_we = 1'b0; prev_d = '0; prev_a = 7'd0;

        // Write sweep over all addresses (R2, R4, R6).
        for (int a = 0; a < 128; a++) step(1'b1, pat(a), 7'(a), GAP, 1'b1);
        step(1'b0, 32'd0, 7'h07, GAP, 1'b1);
        for (int i = 0; i < NB; i++)
            check("R8 breakpoint enable", {39'd0, bkpt_en[i]}, {39'd0, pat(8'h50 + i)[0]});
        for (int i = 0; i < NW; i++)
            check("R8 watchpoint enable", {39'd0, wpt_en[i]}, {39'd0, pat(8'h70 + i)[0]});
        check("R8 vector catch enable", {39'd0, vcatch_en}, 40'd1);

        // Read sweep over all addresses (R2, R3, R4, R6).
        for (int a = 0; a < 128; a++) step(1'b0, 32'd0, 7'(a), GAP, 1'b1);

        // Writing zero disables (R8).
        step(1'b1, 32'd0, 7'h51, GAP, 1'b1);
        step(1'b1, 32'd0, 7'h07, GAP, 1'b1);
        step(1'b0, 32'd0, 7'h00, GAP, 1'b1);
        check("R8 breakpoint 1 disabled", {39'd0, bkpt_en[1]}, 40'd0);
        check("R8 vector catch disabled", {39'd0, vcatch_en}, 40'd0);

        // Busy capture drops the update; repeat succeeds (R5).
        step(1'b1, 32'h1234_5678, 7'h40, 0, 1'b1);
        step(1'b1, 32'hDEAD_BEEF, 7'h41, GAP, 1'b0);
        step(1'b0, 32'd0, 7'h41, GAP, 1'b1);
        step(1'b0, 32'd0, 7'h07, GAP, 1'b1);

        // Ready boundary at ACC_LAT versus ACC_LAT+1 idle cycles (R10).
        step(1'b1, 32'h0BAD_F00D, 7'h60, LAT, 1'b1);
        step(1'b0, 32'd0, 7'h60, GAP, 1'b0);
        step(1'b0, 32'd0, 7'h60, LAT + 1, 1'b1);
        step(1'b0, 32'd0, 7'h61, GAP, 1'b1);

        // Deselected scan has no effect (R9).
        step(1'b0, 32'd0, 7'h07, GAP, 1'b1);
        scan(1'b0, 1'b1, 32'hFFFF_FFFF, 7'h07, GAP, ob);
        step(1'b0, 32'd0, 7'h07, GAP, 1'b1);
        step(1'b0, 32'd0, 7'h00, GAP, 1'b1);
        check("R9 vector catch untouched", {39'd0, vcatch_en}, 40'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule